// File: doc/BRIEF.md
# Word-FIFO SPI Flash Master

This block is a register-mapped SPI master for talking to a serial flash device over a single data line in each direction. Software pushes 32-bit words into a transmit FIFO through one of four transmit ports. Each port tells the block how many bytes of the written word are valid: four, one, two or three. The serial engine sends those bytes least significant byte first and sends each byte most significant bit first. For every transmit word it collects the same number of bytes from MISO and pushes them into a receive FIFO as one word. A short word lands in the upper bytes, so software right-aligns it with a single shift.

Software drives chip select by hand through the configuration register. The SCLK rate is the reference clock divided by a power of two. Four interrupt flags report on the FIFOs: receive overflow, receive data available, transmit room and transmit underflow. They are combined with a mask into one interrupt line. The mask is changed through separate set and clear registers.

Top module: `flash_word_spi`

## Requirements
- R1: The configuration field at bits 5:3 holds n. While a word is being shifted, every SCLK high phase and every SCLK low phase lasts 2^n reference clocks (n=0 divides by 2, n=7 divides by 256).
- R2: `spi_cs_n` is low exactly when configuration bit 14 (force) is 1 and configuration bit 10 (select level) is 0. After reset, bit 10 is 1 and bit 14 is 0, so the configuration reads 0x400 and `spi_cs_n` is high.
- R3: Word address 6 queues all 4 bytes of the written word. Addresses 7, 8 and 9 queue only the lowest 1, 2 or 3 bytes. Exactly that many bytes are shifted out for the word.
- R4: Bytes of a word leave least significant byte first, and each byte goes out MSB first. This is SPI mode 0: SCLK idles low, MOSI changes only on the falling edge, and MISO is sampled on the rising edge.
- R5: A received word of n bytes has received byte k at bits 8*(4-n+k)+7 down to 8*(4-n+k). Bytes below these are zero. Reading address 10 returns the head of the receive FIFO and pops it.
- R6: The status register at address 2 has bit 0 = RX overflow, bit 1 = RX available (RX count >= RX threshold, address 12), bit 2 = TX room (TX count < TX threshold, address 11) and bit 3 = TX underflow. Both thresholds reset to 1. Bits 0 and 3 are sticky and are cleared by writing 1 to them at address 2.
- R7: Writing 1s to address 3 sets mask bits, and writing 1s to address 4 clears them. Address 5 reads the mask. `irq` is high when any status bit with its mask bit set is 1.
- R8: Bit 0 of address 1 enables the engine. Clearing it stops shifting at once, returns SCLK low, and no more bytes are sent.
- R9: Each FIFO holds 63 words. A write to a full TX FIFO is dropped. A word completed while the RX FIFO is full is discarded and sets RX overflow.
- R10: TX underflow is set whenever the engine is enabled, chip select is asserted and the TX FIFO is empty.
- R11: While chip select is deasserted the engine stays idle with SCLK low, and queued transmit words stay queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX at address 10) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Masked interrupt |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench aims at the byte-count paths. A one-, two- or three-byte port that sent four bytes, or a short word placed in the low bytes instead of the high bytes, would show up as extra MOSI frames or as a mismatched receive word. The FIFO limits are exercised by writing 64 transmit words while select is released. If the 64th word were not dropped, a 64th byte would appear on MOSI. One more word after 63 replies have been collected must set overflow and must not corrupt the stored words. Each SCLK high phase is timed on every clock against the programmed divider. Clearing the enable in the middle of a byte must freeze SCLK low, whereas an engine that finished the byte would still emit frames.

// File: rtl/flash_spi_pkg.sv
package flash_spi_pkg;

    localparam logic [3:0] A_CFG     = 4'd0;
    localparam logic [3:0] A_ENABLE  = 4'd1;
    localparam logic [3:0] A_STATUS  = 4'd2;
    localparam logic [3:0] A_MSET    = 4'd3;
    localparam logic [3:0] A_MCLR    = 4'd4;
    localparam logic [3:0] A_MASK    = 4'd5;
    localparam logic [3:0] A_TX4     = 4'd6;
    localparam logic [3:0] A_TX1     = 4'd7;
    localparam logic [3:0] A_TX2     = 4'd8;
    localparam logic [3:0] A_TX3     = 4'd9;
    localparam logic [3:0] A_RXDATA  = 4'd10;
    localparam logic [3:0] A_TXTHR   = 4'd11;
    localparam logic [3:0] A_RXTHR   = 4'd12;

    localparam int CFG_DIV_LSB = 3;
    localparam int CFG_SEL_BIT = 10;
    localparam int CFG_FRC_BIT = 14;

    localparam int ST_RXOVF  = 0;
    localparam int ST_RXAV   = 1;
    localparam int ST_TXROOM = 2;
    localparam int ST_TXUND  = 3;
    localparam int ST_BITS   = 4;

    typedef struct packed {
        logic [1:0]  nb_m1;
        logic [31:0] data;
    } tx_entry_t;

endpackage

// File: rtl/fspi_word_fifo.sv
module fspi_word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 63,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (q.cnt == CW'(DEPTH));
    assign empty    = (q.cnt == '0);
    assign count    = q.cnt;
    assign pop_data = mem[q.rd];
    assign push_ok  = push && !full;
    assign pop_ok   = pop && !empty;

    always_comb begin
        d = q;
        if (push_ok) d.wr = step(q.wr);
        if (pop_ok)  d.rd = step(q.rd);
        case ({push_ok, pop_ok})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wr] <= push_data;
    end

endmodule

// File: rtl/fspi_shift_engine.sv
module fspi_shift_engine
    import flash_spi_pkg::*;
#(
    parameter int DIV_W = 3,
    localparam int HW = (1 << DIV_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [DIV_W-1:0] div,
    input  logic             tx_valid,
    input  tx_entry_t        tx_entry,
    input  logic             miso,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [31:0]      rx_word,
    output logic             sclk,
    output logic             mosi
);

    typedef struct packed {
        logic          run;
        logic          sclk;
        logic [HW-1:0] hcnt;
        logic [2:0]    bitn;
        logic [2:0]    left;
        logic [23:0]   rem;
        logic [7:0]    sh;
        logic [7:0]    rxb;
        logic [23:0]   acc;
    } eng_st_t;

    eng_st_t q, d;
    logic [HW-1:0] lim;

    assign lim     = (HW'(1) << div) - 1'b1;
    assign sclk    = q.sclk;
    assign mosi    = q.run ? q.sh[7] : 1'b0;
    assign rx_word = {q.rxb, q.acc};

    always_comb begin
        d       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        if (!active) begin
            d.run  = 1'b0;
            d.sclk = 1'b0;
            d.hcnt = '0;
        end else if (!q.run) begin
            if (tx_valid) begin
                tx_pop = 1'b1;
                d.run  = 1'b1;
                d.sclk = 1'b0;
                d.hcnt = '0;
                d.bitn = '0;
                d.left = {1'b0, tx_entry.nb_m1} + 3'd1;
                d.sh   = tx_entry.data[7:0];
                d.rem  = tx_entry.data[31:8];
                d.acc  = '0;
            end
        end else if (q.hcnt != lim) begin
            d.hcnt = q.hcnt + 1'b1;
        end else begin
            d.hcnt = '0;
            d.sclk = !q.sclk;
            if (!q.sclk) begin
                d.rxb = {q.rxb[6:0], miso};
            end else if (q.bitn != 3'd7) begin
                d.bitn = q.bitn + 3'd1;
                d.sh   = {q.sh[6:0], 1'b0};
            end else begin
                d.bitn = '0;
                d.acc  = {q.rxb, q.acc[23:8]};
                if (q.left == 3'd1) begin
                    d.run   = 1'b0;
                    rx_push = 1'b1;
                end else begin
                    d.left = q.left - 3'd1;
                    d.sh   = q.rem[7:0];
                    d.rem  = {8'h00, q.rem[23:8]};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/flash_word_spi.sv
module flash_word_spi
    import flash_spi_pkg::*;
#(
    parameter int FIFO_DEPTH = 63,
    parameter int DIV_W      = 3,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);

    typedef struct packed {
        logic [DIV_W-1:0]   div;
        logic               sel;
        logic               frc;
        logic               en;
        logic               ovf;
        logic               und;
        logic [ST_BITS-1:0] mask;
        logic [CNT_W-1:0]   txthr;
        logic [CNT_W-1:0]   rxthr;
    } regs_t;

    regs_t r_q, r_d;

    tx_entry_t          tx_in, tx_head;
    logic               tx_push, tx_pop, tx_full, tx_empty;
    logic [CNT_W-1:0]   tx_count;
    logic [31:0]        rx_word, rx_head;
    logic               rx_push, rx_pop, rx_full, rx_empty;
    logic [CNT_W-1:0]   rx_count;
    logic               eng_active, ovf_clr, und_clr;
    logic [ST_BITS-1:0] stat_vec;
    logic [ST_BITS-1:0] mask_q;

    assign spi_cs_n   = !(r_q.frc && !r_q.sel);
    assign eng_active = r_q.en && !spi_cs_n;
    assign mask_q     = r_q.mask;

    always_comb begin
        tx_in.data = bus_wdata;
        case (bus_addr)
            A_TX1:   tx_in.nb_m1 = 2'd0;
            A_TX2:   tx_in.nb_m1 = 2'd1;
            A_TX3:   tx_in.nb_m1 = 2'd2;
            default: tx_in.nb_m1 = 2'd3;
        endcase
    end

    assign tx_push = bus_wr && (bus_addr >= A_TX4) && (bus_addr <= A_TX3);
    assign rx_pop  = bus_rd && (bus_addr == A_RXDATA);
    assign ovf_clr = bus_wr && (bus_addr == A_STATUS) && bus_wdata[ST_RXOVF];
    assign und_clr = bus_wr && (bus_addr == A_STATUS) && bus_wdata[ST_TXUND];

    always_comb begin
        stat_vec            = '0;
        stat_vec[ST_RXOVF]  = r_q.ovf;
        stat_vec[ST_RXAV]   = (rx_count >= r_q.rxthr);
        stat_vec[ST_TXROOM] = (tx_count < r_q.txthr);
        stat_vec[ST_TXUND]  = r_q.und;
    end

    assign irq = |(stat_vec & r_q.mask);

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (bus_addr)
                A_CFG: begin
                    r_d.div = bus_wdata[CFG_DIV_LSB +: DIV_W];
                    r_d.sel = bus_wdata[CFG_SEL_BIT];
                    r_d.frc = bus_wdata[CFG_FRC_BIT];
                end
                A_ENABLE: r_d.en    = bus_wdata[0];
                A_MSET:   r_d.mask  = r_q.mask | bus_wdata[ST_BITS-1:0];
                A_MCLR:   r_d.mask  = r_q.mask & ~bus_wdata[ST_BITS-1:0];
                A_TXTHR:  r_d.txthr = bus_wdata[CNT_W-1:0];
                A_RXTHR:  r_d.rxthr = bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
        if (ovf_clr) r_d.ovf = 1'b0;
        if (und_clr) r_d.und = 1'b0;
        if (rx_push && rx_full) r_d.ovf = 1'b1;
        if (eng_active && tx_empty) r_d.und = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.sel   <= 1'b1;
            r_q.txthr <= CNT_W'(1);
            r_q.rxthr <= CNT_W'(1);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CFG: begin
                bus_rdata[CFG_DIV_LSB +: DIV_W] = r_q.div;
                bus_rdata[CFG_SEL_BIT]          = r_q.sel;
                bus_rdata[CFG_FRC_BIT]          = r_q.frc;
            end
            A_ENABLE: bus_rdata[0]                 = r_q.en;
            A_STATUS: bus_rdata[ST_BITS-1:0]       = stat_vec;
            A_MASK:   bus_rdata[ST_BITS-1:0]       = r_q.mask;
            A_RXDATA: bus_rdata                    = rx_empty ? 32'h0 : rx_head;
            A_TXTHR:  bus_rdata[CNT_W-1:0]         = r_q.txthr;
            A_RXTHR:  bus_rdata[CNT_W-1:0]         = r_q.rxthr;
            default: ;
        endcase
    end

    fspi_word_fifo #(.WIDTH($bits(tx_entry_t)), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(tx_in),
        .pop(tx_pop), .pop_data(tx_head),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    fspi_word_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_word),
        .pop(rx_pop), .pop_data(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    fspi_shift_engine #(.DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .active(eng_active), .div(r_q.div),
        .tx_valid(!tx_empty), .tx_entry(tx_head),
        .miso(spi_miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .sclk(spi_sclk), .mosi(spi_mosi)
    );

endmodule

// File: rtl/fspi_checker.sv
module fspi_checker #(
    parameter int DEPTH = 63,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          sclk,
    input logic          mosi,
    input logic          en,
    input logic          ovf_clr,
    input logic          irq,
    input logic [3:0]    stat,
    input logic [3:0]    mask,
    input logic [CW-1:0] tx_count
);

    assert_idle_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sclk);

    assert_mosi_high_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_mosi_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    assert_stop_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sclk);

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[0] && !ovf_clr) |=> stat[0]);

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 4'h0) |-> !irq);

    assert_tx_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(DEPTH));

endmodule

bind flash_word_spi fspi_checker #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .en(eng_active), .ovf_clr(ovf_clr), .irq(irq), .stat(stat_vec),
    .mask(mask_q), .tx_count(tx_count)
);

// File: tb/flash_word_spi_tb_top.sv
`timescale 1ns/1ps
module flash_word_spi_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    always #2.5 clk = ~clk;

    flash_word_spi dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_chk = 0, n_fail = 0;
    int pc_chk = 0, pc_fail = 0;

    // Flash-side model: replies from mq, records MOSI bytes in got
    logic [7:0] mq [0:1023];
    logic [7:0] got [0:1023];
    int mwr = 0, mrd = 0, gcnt = 0;
    logic [2:0] sbit = '0;
    logic [7:0] ssh = '0;

    assign spi_miso = (mrd < mwr) ? mq[mrd][3'd7 - sbit] : 1'b1;

    always @(posedge spi_sclk) begin
        ssh = {ssh[6:0], spi_mosi};
        if (sbit == 3'd7) begin
            got[gcnt] = ssh;
            gcnt++;
            sbit = '0;
            if (mrd < mwr) mrd++;
        end else begin
            sbit++;
        end
    end

    // Per-clock reference: SCLK high phase length vs programmed divider (R1)
    int exp_div = 0;
    bit hi_chk_on = 1'b1;
    int hi_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_sclk) hi_len++;
            else if (hi_len != 0) begin
                if (hi_chk_on) begin
                    pc_chk++;
                    if (hi_len != (1 << exp_div)) begin
                        pc_fail++;
                        $display("FAIL R1 high phase actual=%0d expected=%0d", hi_len, 1 << exp_div);
                    end
                end
                hi_len = 0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_rx(input int need);
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(4'd2, s);
            if (s[1] && gcnt >= need) break;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    localparam logic [31:0] CS_ON  = 32'h4000;
    localparam logic [31:0] CS_OFF = 32'h4400;

    logic [31:0] v;
    int base;

    initial begin : watchdog
        #750000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk + pc_chk, n_fail + pc_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // Reset state
        chk("R2 reset cs_n", {31'b0, spi_cs_n}, 32'h1);
        chk("R4 reset sclk idle low", {31'b0, spi_sclk}, 32'h0);
        rd(4'd0, v); chk("R2 reset cfg", v, 32'h400);
        rd(4'd2, v); chk("R6 reset status", v, 32'h4);
        chk("R7 reset irq", {31'b0, irq}, 32'h0);

        // Released select: word stays queued (R11)
        wr(4'd1, 32'h1);
        wr(4'd0, CS_OFF);
        wr(4'd6, 32'hA1B2C3D4);
        idle(100);
        chk("R11 no frames while released", gcnt, 0);
        chk("R2 force with level 1", {31'b0, spi_cs_n}, 32'h1);
        rd(4'd2, v); chk("R6 tx room cleared at threshold", v & 32'h4, 32'h0);

        // Full word (R3, R4, R5)
        mq[mwr++] = 8'h11; mq[mwr++] = 8'h22; mq[mwr++] = 8'h33; mq[mwr++] = 8'h44;
        wr(4'd0, CS_ON);
        chk("R2 select asserted", {31'b0, spi_cs_n}, 32'h0);
        wait_rx(4);
        chk("R3 four frames", gcnt, 4);
        chk("R4 byte0", got[0], 8'hD4); chk("R4 byte1", got[1], 8'hC3);
        chk("R4 byte2", got[2], 8'hB2); chk("R4 byte3", got[3], 8'hA1);
        rd(4'd10, v); chk("R5 full rx word", v, 32'h44332211);

        // One byte (R3, R5)
        base = gcnt;
        mq[mwr++] = 8'h5A;
        wr(4'd7, 32'hFFFFFFE5);
        wait_rx(base + 1);
        idle(40);
        chk("R3 one frame", gcnt - base, 1);
        chk("R4 one-byte value", got[base], 8'hE5);
        rd(4'd10, v); chk("R5 one-byte packing", v, 32'h5A000000);

        // Three bytes at divider 2 (R1, R3, R5)
        exp_div = 2;
        wr(4'd0, CS_ON | (32'd2 << 3));
        base = gcnt;
        mq[mwr++] = 8'h01; mq[mwr++] = 8'h02; mq[mwr++] = 8'h03;
        wr(4'd9, 32'h99123456);
        wait_rx(base + 3);
        idle(40);
        chk("R3 three frames", gcnt - base, 3);
        chk("R4 three-byte b0", got[base], 8'h56);
        chk("R4 three-byte b2", got[base+2], 8'h12);
        rd(4'd10, v); chk("R5 three-byte packing", v, 32'h03020100);

        // Two bytes at divider 7 (R1, R3, R5)
        exp_div = 7;
        wr(4'd0, CS_ON | (32'd7 << 3));
        base = gcnt;
        mq[mwr++] = 8'hAA; mq[mwr++] = 8'hBB;
        wr(4'd8, 32'h7777BEEF);
        wait_rx(base + 2);
        idle(300);
        chk("R3 two frames", gcnt - base, 2);
        chk("R4 two-byte b0", got[base], 8'hEF);
        chk("R4 two-byte b1", got[base+1], 8'hBE);
        rd(4'd10, v); chk("R5 two-byte packing", v, 32'hBBAA0000);

        // Underflow (R10, R6)
        rd(4'd2, v); chk("R10 underflow while selected and empty", v & 32'h8, 32'h8);
        wr(4'd0, CS_OFF);
        wr(4'd2, 32'h8);
        idle(10);
        rd(4'd2, v); chk("R6 underflow write-1 clear", v & 32'h8, 32'h0);

        // Interrupt mask (R7)
        exp_div = 0;
        wr(4'd3, 32'h2);
        rd(4'd5, v); chk("R7 mask readback", v, 32'h2);
        chk("R7 irq quiet with rx empty", {31'b0, irq}, 32'h0);
        mq[mwr++] = 8'h77;
        wr(4'd7, 32'h00000033);
        wr(4'd0, CS_ON);
        wait_rx(gcnt + 1);
        chk("R7 irq on rx available", {31'b0, irq}, 32'h1);
        wr(4'd4, 32'hFFFFFFFF);
        chk("R7 irq masked off", {31'b0, irq}, 32'h0);
        rd(4'd10, v); chk("R5 word under mask test", v, 32'h77000000);

        // Depth, drop and overflow (R9)
        wr(4'd0, CS_OFF);
        wr(4'd2, 32'h9);
        base = gcnt;
        for (int k = 0; k < 64; k++) wr(4'd7, k);
        for (int k = 0; k < 64; k++) mq[mwr++] = 8'h80 + 8'(k);
        wr(4'd0, CS_ON);
        idle(2500);
        chk("R9 full tx write dropped", gcnt - base, 63);
        chk("R9 last kept byte", got[base+62], 8'd62);
        rd(4'd2, v); chk("R9 no overflow at exactly 63", v & 32'h1, 32'h0);
        wr(4'd7, 32'hC8);
        idle(40);
        rd(4'd2, v); chk("R9 overflow on 64th word", v & 32'h1, 32'h1);
        chk("R4 extra word sent", got[base+63], 8'hC8);
        wr(4'd2, 32'h1);
        rd(4'd2, v); chk("R6 overflow write-1 clear", v & 32'h1, 32'h0);
        for (int k = 0; k < 63; k++) begin
            rd(4'd10, v);
            if (k == 0 || k == 62) chk("R9 stored rx word", v, {8'h80 + 8'(k), 24'h0});
        end
        rd(4'd2, v); chk("R9 rx drained", v & 32'h2, 32'h0);

        // Disable mid-word (R8)
        exp_div = 7;
        wr(4'd0, CS_ON | (32'd7 << 3));
        wr(4'd6, 32'h01020304);
        idle(300);
        hi_chk_on = 1'b0;
        wr(4'd1, 32'h0);
        base = gcnt;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (spi_sclk) begin
                chk("R8 sclk stops on disable", 32'h1, 32'h0);
                break;
            end
        end
        chk("R8 no frames after disable", gcnt - base, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk + pc_chk, n_fail + pc_fail);
        $finish;
    end

endmodule